// File: doc/BRIEF.md
# Conversion Clock and Sample Window Timer

This block produces the conversion clock enable for two converters, A (index 0) and B (index 1), from the system clock. For each converter it also times the sampling window that comes before a conversion. Each converter has a divider setting and a sample-window count. When a sample start is accepted, three things happen. The converter's divider is brought back to phase zero. A sampling-active level is raised for a whole number of conversion clocks. A one-cycle start-convert pulse is then issued.

The window length depends on three things: the scan mode, whether the sample is the first one of its scan, and whether a sequential scan has just moved to the other converter. The slot sequencer around the block supplies these as inputs. Each converter receives one sample start at a time from that sequencer.

Top module: `adc_smp_timer`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `sampling` and `conv_start` are low for both converters.
- R2: A divider setting of 0 gives a conversion clock ratio R of 2 system clocks. A setting N>0 gives R = N+1. `clk_en` is a single-cycle pulse that repeats every R system clocks.
- R3: An accepted sample start restarts the divider phase. The first `clk_en` then appears R-1 cycles after the first cycle in which `sampling` is high.
- R4: The sampling window lasts W = C+2 conversion clocks, where C is the effective window count. `sampling` is therefore high for exactly W*R consecutive system clocks, and exactly W `clk_en` pulses fall inside that window.
- R5: A selected window count above 7 is treated as 7, so no window exceeds 9 conversion clocks.
- R6: `scan_mode` encodings are 0 sequential, 1 locked parallel, 2 independent parallel, and 3, which behaves like 1. Converter A always uses `win_set[0]`. Converter B uses `win_set[1]` only in mode 2, and uses `win_set[0]` in every other mode.
- R7: A sample start with `smp_first` low uses C=0, which gives a 2-clock window.
- R8: In mode 0, a sample start with `smp_xconv` high uses C=0.
- R9: `conv_start` is high for exactly one cycle. That cycle immediately follows the last cycle of `sampling`.
- R10: A sample start that arrives while that converter's window is open is ignored. The window length and the divider phase stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scan_mode | input | 2 | Scan mode encoding (see R6) |
| div_set | input | 2 x DIV_W | Divider setting per converter, index 0 = A |
| win_set | input | 2 x WIN_W | Sample-window count per converter |
| smp_start | input | 2 | Sample start request per converter |
| smp_first | input | 2 | Requested sample is the first of its scan |
| smp_xconv | input | 2 | Requested sample moved from the other converter |
| clk_en | output | 2 | Conversion clock enable pulse per converter |
| sampling | output | 2 | Sampling window active per converter |
| conv_start | output | 2 | One-cycle start-convert pulse per converter |

## Verification
The assertions take two things for granted. First, a converter's divider setting stays stable while its window is open. Second, the mode, count, first and cross inputs only need to be valid in the cycle a start is accepted. The stimulus respects both. It changes configuration only at the start of a vector, while both converters are idle. It holds the configuration constant until `conv_start` has been seen. The one deliberate exception is a start pulse injected mid-window to exercise R10.

// File: rtl/adc_smp_timer_pkg.sv
// Package: shared scan mode type for the sample window timer.
package adc_smp_timer_pkg;

    typedef enum logic [1:0] {
        MODE_SEQ       = 2'd0,
        MODE_PAR_LOCK  = 2'd1,
        MODE_PAR_INDEP = 2'd2,
        MODE_RSVD      = 2'd3
    } scan_mode_e;

endpackage

// File: rtl/smp_clk_div.sv
// Module: smp_clk_div
// Produces a clock-enable pulse every R system clocks.
// R is 2 for a setting of 0, and N+1 for a setting of N.
// Assumes div_set stays stable while a sampling window is open.
module smp_clk_div #(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_set,
    input  logic             restart,
    output logic             clk_en
);

    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] limit;

    // Terminal count is R-1; a setting of 0 maps to ratio 2.
    always_comb begin
        limit = (div_set == '0) ? DIV_W'(1) : div_set;
    end

    // Phase counter: cleared by restart, wraps at the terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart || (cnt_q >= limit)) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + DIV_W'(1);
        end
    end

    assign clk_en = (cnt_q == limit);

    AST_EN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en |=> !clk_en);                                     // R2
    AST_RESTART_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !clk_en);                                    // R3

endmodule

// File: rtl/smp_win_sel.sv
// Module: smp_win_sel
// Selects the effective window count for one converter and adds 2.
// The count comes from the converter itself or from converter A, chosen by scan mode.
// It is clamped to MAX_WIN_CNT, and forced to 0 for a non-first sample
// or for a sequential cross-over sample.
module smp_win_sel
    import adc_smp_timer_pkg::*;
#(
    parameter int WIN_W       = 4,
    parameter int MAX_WIN_CNT = 7,
    parameter int CLK_W       = 4,
    parameter int CONV_IDX    = 0
) (
    input  scan_mode_e       mode,
    input  logic [WIN_W-1:0] win_own,
    input  logic [WIN_W-1:0] win_lead,
    input  logic             first,
    input  logic             xconv,
    output logic [CLK_W-1:0] win_clocks
);

    logic [WIN_W-1:0] sel_cnt;
    logic [WIN_W-1:0] clamp_cnt;
    logic [WIN_W-1:0] eff_cnt;

    // Source choice, clamp and default override for the window count.
    always_comb begin
        sel_cnt = win_own;
        if ((CONV_IDX != 0) && (mode != MODE_PAR_INDEP)) begin
            sel_cnt = win_lead;
        end
        clamp_cnt = (sel_cnt > WIN_W'(MAX_WIN_CNT)) ? WIN_W'(MAX_WIN_CNT) : sel_cnt;
        if (!first || ((mode == MODE_SEQ) && xconv)) begin
            eff_cnt = '0;
        end else begin
            eff_cnt = clamp_cnt;
        end
        win_clocks = CLK_W'(eff_cnt) + CLK_W'(2);
    end

endmodule

// File: rtl/smp_window.sv
// Module: smp_window
// Opens a sampling window on an accepted start.
// Counts win_clocks conversion-clock enables, then pulses conv_start for one cycle.
// A start that arrives while the window is open is ignored.
module smp_window #(
    parameter int CLK_W      = 4,
    parameter int MAX_CLOCKS = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             clk_en,
    input  logic [CLK_W-1:0] win_clocks,
    output logic             accept,
    output logic             sampling,
    output logic             conv_start
);

    logic             active_q;
    logic [CLK_W-1:0] remain_q;
    logic             conv_q;

    assign accept     = start && !active_q;
    assign sampling   = active_q;
    assign conv_start = conv_q;

    // Window state: load on accept, count down on clk_en, fire on the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            remain_q <= '0;
            conv_q   <= 1'b0;
        end else begin
            conv_q <= 1'b0;
            if (accept) begin
                active_q <= 1'b1;
                remain_q <= win_clocks;
            end else if (active_q && clk_en) begin
                if (remain_q == CLK_W'(1)) begin
                    active_q <= 1'b0;
                    conv_q   <= 1'b1;
                end else begin
                    remain_q <= remain_q - CLK_W'(1);
                end
            end
        end
    end

    AST_CONV_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);                             // R9
    AST_CONV_AFTER_WIN: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> ($past(sampling) && !sampling));          // R9
    AST_REMAIN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        sampling |-> ((remain_q != '0) && (remain_q <= CLK_W'(MAX_CLOCKS)))); // R5
    AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
        (sampling && !clk_en) |=> (sampling && $stable(remain_q))); // R10

endmodule

// File: rtl/adc_smp_timer.sv
// Module: adc_smp_timer (top)
// Per-converter conversion clock enable and sample window timing for converters A (0) and B (1).
// Assumes the sequencer issues one start per converter at a time.
// Assumes div_set stays stable while that converter's window is open.
module adc_smp_timer
    import adc_smp_timer_pkg::*;
#(
    parameter int DIV_W       = 4,
    parameter int WIN_W       = 4,
    parameter int MAX_WIN_CNT = 7
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [1:0]            scan_mode,
    input  logic [1:0][DIV_W-1:0] div_set,
    input  logic [1:0][WIN_W-1:0] win_set,
    input  logic [1:0]            smp_start,
    input  logic [1:0]            smp_first,
    input  logic [1:0]            smp_xconv,
    output logic [1:0]            clk_en,
    output logic [1:0]            sampling,
    output logic [1:0]            conv_start
);

    localparam int NUM_CONV   = 2;
    localparam int MAX_CLOCKS = MAX_WIN_CNT + 2;
    localparam int CLK_W      = $clog2(MAX_CLOCKS + 1);

    scan_mode_e mode_w;
    assign mode_w = scan_mode_e'(scan_mode);

    for (genvar gi = 0; gi < NUM_CONV; gi++) begin : g_conv
        logic             restart_w;
        logic [CLK_W-1:0] clocks_w;

        smp_win_sel #(
            .WIN_W      (WIN_W),
            .MAX_WIN_CNT(MAX_WIN_CNT),
            .CLK_W      (CLK_W),
            .CONV_IDX   (gi)
        ) u_sel (
            .mode      (mode_w),
            .win_own   (win_set[gi]),
            .win_lead  (win_set[0]),
            .first     (smp_first[gi]),
            .xconv     (smp_xconv[gi]),
            .win_clocks(clocks_w)
        );

        smp_clk_div #(
            .DIV_W(DIV_W)
        ) u_div (
            .clk    (clk),
            .rst_n  (rst_n),
            .div_set(div_set[gi]),
            .restart(restart_w),
            .clk_en (clk_en[gi])
        );

        smp_window #(
            .CLK_W     (CLK_W),
            .MAX_CLOCKS(MAX_CLOCKS)
        ) u_win (
            .clk       (clk),
            .rst_n     (rst_n),
            .start     (smp_start[gi]),
            .clk_en    (clk_en[gi]),
            .win_clocks(clocks_w),
            .accept    (restart_w),
            .sampling  (sampling[gi]),
            .conv_start(conv_start[gi])
        );
    end

endmodule

// File: tb/adc_smp_timer_bench.sv
`timescale 1ns/1ps
module adc_smp_timer_bench;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [1:0]      scan_mode = '0;
    logic [1:0][3:0] div_set = '0;
    logic [1:0][3:0] win_set = '0;
    logic [1:0]      smp_start = '0;
    logic [1:0]      smp_first = '0;
    logic [1:0]      smp_xconv = '0;
    logic [1:0]      clk_en;
    logic [1:0]      sampling;
    logic [1:0]      conv_start;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    adc_smp_timer u_adc_smp_timer (
        .clk(clk), .rst_n(rst_n), .scan_mode(scan_mode), .div_set(div_set),
        .win_set(win_set), .smp_start(smp_start), .smp_first(smp_first),
        .smp_xconv(smp_xconv), .clk_en(clk_en), .sampling(sampling),
        .conv_start(conv_start)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Expected window in conversion clocks, derived from R4..R8.
    function automatic int exp_clocks(input int c, input int wa, input int wb,
                                      input int md, input bit fs, input bit xc);
        int cnt;
        cnt = (c == 1 && md == 2) ? wb : wa;
        if (cnt > 7) cnt = 7;
        if (!fs || (md == 0 && xc)) cnt = 0;
        return cnt + 2;
    endfunction

    task automatic run_vec(input int c, input int dv, input int wa, input int wb,
                           input int md, input bit fs, input bit xc, input int poke,
                           input string tag);
        int r, w, smp_len, first_en, conv_k, en_cnt, last_en;
        bit gap_ok;
        r = (dv == 0) ? 2 : dv + 1;
        w = exp_clocks(c, wa, wb, md, fs, xc);
        smp_len = 0; first_en = -1; conv_k = -1; en_cnt = 0; last_en = -1; gap_ok = 1'b1;
        @(negedge clk);
        div_set[c] = dv[3:0];
        win_set[0] = wa[3:0];
        win_set[1] = wb[3:0];
        scan_mode = md[1:0];
        smp_first[c] = fs;
        smp_xconv[c] = xc;
        smp_start[c] = 1'b1;
        @(negedge clk);
        smp_start[c] = 1'b0;
        for (int k = 0; k < 600; k++) begin
            if (sampling[c]) smp_len++;
            if (clk_en[c] && sampling[c]) begin
                en_cnt++;
                if (first_en < 0) first_en = k;
                if (last_en >= 0 && (k - last_en) != r) gap_ok = 1'b0;
                last_en = k;
            end
            if (conv_start[c]) begin
                conv_k = k;
                break;
            end
            smp_start[c] = (k == poke);
            @(negedge clk);
        end
        smp_start[c] = 1'b0;
        check(gap_ok, {"R2 ", tag}, last_en, r);
        check(first_en == r - 1, {"R3 ", tag}, first_en, r - 1);
        check(smp_len == w * r, {"R4 ", tag}, smp_len, w * r);
        check(en_cnt == w, {"R4 ", tag}, en_cnt, w);
        check(conv_k == w * r, {"R9 ", tag}, conv_k, w * r);
        @(negedge clk);
        check(conv_start[c] == 1'b0, {"R9 ", tag}, int'(conv_start[c]), 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        check(sampling == 2'b00, "R1 reset", int'(sampling), 0);
        check(conv_start == 2'b00, "R1 reset", int'(conv_start), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(sampling == 2'b00, "R1 post", int'(sampling), 0);
        check(conv_start == 2'b00, "R1 post", int'(conv_start), 0);

        // R2 R4 R5 R6: divider and count sweep, locked and independent parallel
        for (int c = 0; c < 2; c++)
            for (int dv = 0; dv < 5; dv++)
                for (int w = 0; w < 10; w++)
                    for (int md = 1; md < 3; md++) begin
                        if (c == 0) run_vec(c, dv, w, (w + 3) % 10, md, 1'b1, 1'b0, -1, "sweep");
                        else        run_vec(c, dv, (w + 4) % 10, w, md, 1'b1, 1'b0, -1, "sweep");
                    end

        // R6 R7 R8: all modes with first and cross combinations
        for (int c = 0; c < 2; c++)
            for (int md = 0; md < 4; md++)
                for (int fs = 0; fs < 2; fs++)
                    for (int xc = 0; xc < 2; xc++)
                        run_vec(c, 1, 5, 3, md, fs[0], xc[0], -1, "R6_R7_R8 modes");

        // R5: largest count clamps to 9 clocks
        run_vec(0, 2, 15, 0, 2, 1'b1, 1'b0, -1, "R5 clamp");
        run_vec(1, 2, 0, 15, 2, 1'b1, 1'b0, -1, "R5 clamp");

        // R10: start pulses mid-window are ignored
        run_vec(0, 3, 4, 2, 1, 1'b1, 1'b0, 5, "R10 busy");
        run_vec(1, 0, 1, 6, 2, 1'b1, 1'b0, 2, "R10 busy");
        run_vec(0, 4, 7, 7, 0, 1'b1, 1'b0, 9, "R10 busy");

        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        #750000;
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule